// File: doc/BRIEF.md
# Return Channel Bit-Doubled Codec

This block carries a small set of status and request signals from a receiving card back to a sending card. A 16-bit word is made of eight two-bit slots, and each slot repeats one information bit. Four slots carry general-purpose return lines. The other slots carry a flow-control pause request, a "far end is down" indication and a remote-reset request. One slot is reserved. Every word on this channel is an ordinary data word. No flag bit and no control word are used.

The encoder half samples its request inputs once every eight cycles. It emits one encoded word and then leaves seven idle slots. In the idle slots the valid strobe is low and the word bus is zero. This steady cadence lets the far receiver lock quickly. The decoder half takes each valid received word and checks every slot for a mismatch between its two copies. If any slot is inconsistent, the whole word is thrown away, the held outputs keep their values, and a one-cycle error pulse is raised. A clean word updates all held outputs together. The serial transport and clock recovery sit outside this block.

Top module: `rbc_codec`

## Requirements
- R1: When `tx_valid` is high, bits [2i+1:2i] of `tx_word` are both equal to `line_in[i]`, for i = 0..3.
- R2: When `tx_valid` is high, bits [9:8] of `tx_word` are both equal to `xoff_req`.
- R3: When `tx_valid` is high, bits [11:10] are both equal to `down_req`, and bits [13:12] are both equal to `rreset_req`.
- R4: When `tx_valid` is high, the reserved bits [15:14] are 00.
- R5: `tx_valid` is high for one cycle and then low for exactly seven cycles, and this repeats. During the low cycles `tx_word` is zero. Each word reflects the inputs present at the clock edge that launches it, so input changes during idle slots appear only in the next word.
- R6: A received word with `rx_valid` high and every pair matched updates the outputs on the next edge. `line_out[i]` follows pair [2i+1:2i], `xoff_out` follows [9:8], `far_down` follows [11:10] and `far_reset` follows [13:12]. Pair value 11 gives 1 and 00 gives 0.
- R7: A received word in which any pair, including the reserved pair [15:14], reads 01 or 10 is discarded, and all decoded outputs keep their previous values.
- R8: `rx_err` is high for exactly the one cycle after each discarded word, and is low otherwise.
- R9: A matched reserved pair (00 or 11) has no effect on any decoded output.
- R10: While `rx_valid` is low, the decoded outputs hold, whatever is on `rx_word`.
- R11: While reset is asserted, `tx_valid`, `tx_word`, all decoded outputs and `rx_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 4 | Return lines to send |
| xoff_req | input | 1 | Flow-control pause request to send |
| down_req | input | 1 | Local link-down indication to send |
| rreset_req | input | 1 | Remote-reset request to send |
| tx_word | output | 16 | Encoded word, zero in idle slots |
| tx_valid | output | 1 | High in the slot that carries a word |
| rx_word | input | 16 | Received word |
| rx_valid | input | 1 | Received word present |
| line_out | output | 4 | Held decoded return lines |
| xoff_out | output | 1 | Held decoded pause request |
| far_down | output | 1 | Held decoded far-end-down indication |
| far_reset | output | 1 | Held decoded remote-reset request |
| rx_err | output | 1 | One-cycle pulse per discarded word |

## Verification
The hardest situation to reach is a discard that leaves the outputs unchanged in a way the bench can actually see. A word that agrees with the held state proves nothing. So before each corrupted word, the bench first loads a known clean state. It then sends a corrupted word whose remaining pairs decode to a different value, and it does this once for each of the sixteen single-bit corruptions, the reserved pair included. Input-sampling timing is covered by changing the requests in the middle of an idle gap and checking that the gap stays zero while the next word carries the new values.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned NUM_PAIRS = 8;
  localparam int unsigned WORD_W    = 2 * NUM_PAIRS;

  // pair slot positions (the far end decodes these)
  localparam int unsigned SLOT_XOFF  = 4;
  localparam int unsigned SLOT_DOWN  = 5;
  localparam int unsigned SLOT_RRST  = 6;
  localparam int unsigned SLOT_RSVD  = 7;

  typedef struct packed {
    logic                 rreset;
    logic                 down;
    logic                 xoff;
    logic [NUM_LINES-1:0] lines;
  } rbc_ctl_t;

  // Spread one bit per slot into a duplicated word; reserved slot left 00.
  function automatic logic [WORD_W-1:0] rbc_pack(input rbc_ctl_t c);
    logic [NUM_PAIRS-1:0] slot;
    logic [WORD_W-1:0]    w;
    slot = '0;
    slot[NUM_LINES-1:0] = c.lines;
    slot[SLOT_XOFF]     = c.xoff;
    slot[SLOT_DOWN]     = c.down;
    slot[SLOT_RRST]     = c.rreset;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      w[2*p]   = slot[p];
      w[2*p+1] = slot[p];
    end
    return w;
  endfunction

endpackage

// File: rtl/rbc_rst_sync.sv
module rbc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/rbc_cadence.sv
module rbc_cadence #(
  parameter int unsigned IDLE_SLOTS = 7
) (
  input  logic clk,
  input  logic rst_n,
  output logic send
);
  localparam int unsigned PERIOD = IDLE_SLOTS + 1;
  localparam int unsigned CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign send = (cnt_q == '0);
endmodule

// File: rtl/rbc_encoder.sv
module rbc_encoder
  import rbc_pkg::*;
#(
  parameter int unsigned IDLE_SLOTS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rbc_ctl_t          ctl,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_valid
);
  logic              send;
  logic [WORD_W-1:0] word_d;
  logic              valid_d;

  rbc_cadence #(.IDLE_SLOTS(IDLE_SLOTS)) u_cadence (
    .clk  (clk),
    .rst_n(rst_n),
    .send (send)
  );

  always_comb begin
    valid_d = send;
    word_d  = send ? rbc_pack(ctl) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word  <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_word  <= word_d;
      tx_valid <= valid_d;
    end
  end

  // Checker-side gap counter, kept apart from the cadence counter
  logic [31:0] gap_q;
  logic        seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tx_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1;
    end
  end

  a_r5_cadence: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && seen_q) |-> (gap_q == IDLE_SLOTS));
  a_r5_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (gap_q <= IDLE_SLOTS));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> (tx_word == '0));
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_word[2*SLOT_RSVD+1:2*SLOT_RSVD] == 2'b00));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
    a_r1_pair_dup: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_word[2*p] == tx_word[2*p+1]));
  end
endmodule

// File: rtl/rbc_pair_check.sv
module rbc_pair_check
  import rbc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output rbc_ctl_t          ctl,
  output logic              bad
);
  logic [NUM_PAIRS-1:0] mism;
  logic [NUM_PAIRS-1:0] hi;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign mism[p] = word[2*p] ^ word[2*p+1];
    assign hi[p]   = word[2*p] & word[2*p+1];
  end

  always_comb begin
    bad        = |mism;
    ctl.lines  = hi[NUM_LINES-1:0];
    ctl.xoff   = hi[SLOT_XOFF];
    ctl.down   = hi[SLOT_DOWN];
    ctl.rreset = hi[SLOT_RRST];
  end
endmodule

// File: rtl/rbc_decoder.sv
module rbc_decoder
  import rbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_valid,
  output rbc_ctl_t          held,
  output logic              rx_err
);
  rbc_ctl_t dec;
  logic     bad;
  logic     load_en;
  logic     err_d;
  rbc_ctl_t held_d;

  rbc_pair_check u_check (
    .word(rx_word),
    .ctl (dec),
    .bad (bad)
  );

  always_comb begin
    load_en = rx_valid & ~bad;
    err_d   = rx_valid & bad;
    held_d  = load_en ? dec : held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      rx_err <= 1'b0;
    end else begin
      held   <= held_d;
      rx_err <= err_d;
    end
  end

  a_r7_discard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && bad) |=> $stable(held));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(held));
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && bad) |=> rx_err);
  a_r8_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && bad) |=> !rx_err);
endmodule

// File: rtl/rbc_codec.sv
module rbc_codec
  import rbc_pkg::*;
#(
  parameter int unsigned IDLE_SLOTS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  line_in,
  input  logic        xoff_req,
  input  logic        down_req,
  input  logic        rreset_req,
  output logic [15:0] tx_word,
  output logic        tx_valid,
  input  logic [15:0] rx_word,
  input  logic        rx_valid,
  output logic [3:0]  line_out,
  output logic        xoff_out,
  output logic        far_down,
  output logic        far_reset,
  output logic        rx_err
);
  logic     rst_n_sync;
  rbc_ctl_t tx_ctl;
  rbc_ctl_t rx_held;

  rbc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  always_comb begin
    tx_ctl.lines  = line_in;
    tx_ctl.xoff   = xoff_req;
    tx_ctl.down   = down_req;
    tx_ctl.rreset = rreset_req;
  end

  rbc_encoder #(.IDLE_SLOTS(IDLE_SLOTS)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .ctl     (tx_ctl),
    .tx_word (tx_word),
    .tx_valid(tx_valid)
  );

  rbc_decoder u_dec (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .rx_word (rx_word),
    .rx_valid(rx_valid),
    .held    (rx_held),
    .rx_err  (rx_err)
  );

  assign line_out  = rx_held.lines;
  assign xoff_out  = rx_held.xoff;
  assign far_down  = rx_held.down;
  assign far_reset = rx_held.rreset;

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n_sync |-> (!tx_valid && !rx_err && rx_held == '0));
endmodule

// File: tb/test_rbc_codec.sv
module test_rbc_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  line_in = '0;
  logic        xoff_req = 1'b0, down_req = 1'b0, rreset_req = 1'b0;
  logic [15:0] tx_word;
  logic        tx_valid;
  logic [15:0] rx_word = '0;
  logic        rx_valid = 1'b0;
  logic [3:0]  line_out;
  logic        xoff_out, far_down, far_reset, rx_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rbc_codec i_rbc_codec (
    .clk(clk), .rst_n(rst_n),
    .line_in(line_in), .xoff_req(xoff_req), .down_req(down_req), .rreset_req(rreset_req),
    .tx_word(tx_word), .tx_valid(tx_valid),
    .rx_word(rx_word), .rx_valid(rx_valid),
    .line_out(line_out), .xoff_out(xoff_out), .far_down(far_down),
    .far_reset(far_reset), .rx_err(rx_err)
  );

  // ctl layout {rreset, down, xoff, lines[3:0]}
  function automatic logic [15:0] enc(input logic [6:0] c);
    logic [15:0] w;
    w = '0;
    for (int i = 0; i < 4; i++) w[2*i +: 2] = {2{c[i]}};
    w[9:8]   = {2{c[4]}};
    w[11:10] = {2{c[5]}};
    w[13:12] = {2{c[6]}};
    return w;
  endfunction

  function automatic logic [6:0] outs();
    return {far_reset, far_down, xoff_out, line_out};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [6:0] c);
    {rreset_req, down_req, xoff_req, line_in} = c;
  endtask

  task automatic wait_word();
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
  endtask

  task automatic send_rx(input logic [15:0] w);
    @(negedge clk);
    rx_word = w; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_word = 16'hFFFF;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 tx_valid", tx_valid, 0);
    chk("R11 tx_word", tx_word, 0);
    chk("R11 outs", outs(), 0);
    chk("R11 rx_err", rx_err, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_encode(input logic [6:0] c);
    set_ctl(c);
    wait_word();
    chk("R1 lines", tx_word[7:0], enc(c) & 16'h00FF);
    chk("R2 xoff", tx_word[9:8], {2{c[4]}});
    chk("R3 down/reset", tx_word[13:10], {{2{c[6]}}, {2{c[5]}}});
    chk("R4 reserved", tx_word[15:14], 0);
  endtask

  task automatic t_cadence();
    wait_word();
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 3) set_ctl(7'h5A);
      chk("R5 idle valid", tx_valid, 0);
      chk("R5 idle word", tx_word, 0);
    end
    @(negedge clk);
    chk("R5 next valid", tx_valid, 1);
    chk("R5 new sample", tx_word, enc(7'h5A));
  endtask

  task automatic t_good(input logic [6:0] c, input logic [1:0] rsvd);
    logic [15:0] w;
    w = enc(c);
    w[15:14] = rsvd;
    send_rx(w);
    chk("R6 decode", outs(), c);
    chk("R8 no err", rx_err, 0);
  endtask

  task automatic t_bad();
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 2; v++) begin
        logic [15:0] w;
        t_good(7'h00, 2'b00);
        w = enc(7'h7F);
        w[2*p+v] = ~w[2*p+v];
        send_rx(w);
        chk("R7 discard hold", outs(), 0);
        chk("R8 err pulse", rx_err, 1);
        @(negedge clk);
        chk("R8 err one cycle", rx_err, 0);
      end
    end
  endtask

  task automatic t_no_valid();
    t_good(7'h33, 2'b00);
    @(negedge clk);
    rx_valid = 1'b0; rx_word = enc(7'h4C);
    repeat (3) @(negedge clk);
    chk("R10 hold", outs(), 7'h33);
    chk("R10 no err", rx_err, 0);
  endtask

  initial begin
    t_reset();
    repeat (4) @(negedge clk);
    t_encode(7'h00);
    t_encode(7'h0F);
    t_encode(7'h10);
    t_encode(7'h20);
    t_encode(7'h40);
    t_encode(7'h25);
    t_cadence();
    t_good(7'h15, 2'b00);
    t_good(7'h6A, 2'b00);
    t_good(7'h7F, 2'b00);
    t_good(7'h2C, 2'b11);
    chk("R9 reserved 11", outs(), 7'h2C);
    t_good(7'h2C, 2'b00);
    chk("R9 reserved 00", outs(), 7'h2C);
    t_bad();
    t_no_valid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule